// File: doc/BRIEF.md
# Sawtooth Ramp Tone Channel

This block produces a coarse stepped ramp for a sound synthesizer voice. A 12-bit period divider, with a two-bit global range control that can make it run 16 or 256 times faster, emits a step pulse at a programmable interval. Each step moves a 14-position step counter forward. At the odd positions of that counter a 6-bit rate value is added into an 8-bit accumulator. When the counter wraps, the accumulator goes back to zero, so the accumulator traces a rising staircase that falls back to zero once per 14 steps.

The sample is the top five bits of the accumulator. The result is a ramp with a few coarse levels, and its height is set by the rate. When the enable input is low, the sample is silenced at once. The next clock edge then returns the divider, the step counter and the accumulator to zero, so the next enable starts from a known phase. Register decoding and mixing with other voices are left to the surrounding logic.

Top module: `saw_channel`

## Requirements
- R1: While reset is asserted, and after it is released with the channel disabled, the sample is 0. Reset clears the divider count, the step counter and the accumulator to 0.
- R2: With `range_sel` = 0, the first step occurs on the first rising edge after enable goes high. Each later step follows `period`+1 edges after the previous one.
- R3: With `range_sel` = 1, the step interval is (`period` >> 4)+1 edges. With `range_sel[1]` = 1, the interval is (`period` >> 8)+1 edges, whatever the value of `range_sel[0]`.
- R4: The step counter takes the values 0 to 13. A step taken at value 13 returns the counter to 0 and clears the accumulator. This clear takes precedence over the addition that an odd value would otherwise cause.
- R5: A step taken while the step counter holds an odd value below 13 adds `rate` to the accumulator, modulo 256. A step taken at an even value leaves the accumulator unchanged.
- R6: While enabled, the sample equals accumulator bits 7:3 and is 0 when the accumulator is 0. It follows the accumulator with no extra register.
- R7: When `enable` is low, the sample is 0 at once. The next rising edge clears the step counter, the accumulator and the divider count.
- R8: `rate` is used only at the edge where a step occurs. Changes to it between steps do not alter the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel enable |
| period | input | 12 | Divider reload value |
| rate | input | 6 | Amount added on odd steps |
| range_sel | input | 2 | Global divider range control |
| sample | output | 5 | Ramp sample, accumulator bits 7:3 |

## Verification
A step, and any addition or clear it causes, lands on the accumulator at the rising edge where the divider count reaches zero. The sample reflects it as soon as that edge has passed, so the bench samples two nanoseconds after every edge. Dropping enable affects the sample combinationally, so the bench checks that case one nanosecond after the input changes, before the clearing edge. The reference model advances one step per edge in the same order as the design, so each check compares against the value due at that edge.

// File: rtl/saw_pkg.sv
package saw_pkg;

    typedef enum logic [1:0] {
        RANGE_FINE   = 2'd0,
        RANGE_MID    = 2'd1,
        RANGE_COARSE = 2'd2
    } range_e;

    // The upper control bit wins over the lower one.
    function automatic range_e decode_range(input logic [1:0] sel);
        if (sel[1])      return RANGE_COARSE;
        else if (sel[0]) return RANGE_MID;
        else             return RANGE_FINE;
    endfunction

endpackage

// File: rtl/saw_divider.sv
module saw_divider
    import saw_pkg::*;
#(
    parameter int CNT_W        = 12,
    parameter int MID_SHIFT    = 4,
    parameter int COARSE_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic [1:0]       range_sel,
    output logic             tick
);
    localparam logic [CNT_W-1:0] DEC_FINE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] DEC_MID    = CNT_W'(1) << MID_SHIFT;
    localparam logic [CNT_W-1:0] DEC_COARSE = CNT_W'(1) << COARSE_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;
    range_e     range_now;
    logic       field_zero;
    logic [CNT_W-1:0] dec_amt;

    always_comb begin
        range_now = decode_range(range_sel);
        unique case (range_now)
            RANGE_MID: begin
                field_zero = (state_q.cnt[CNT_W-1:MID_SHIFT] == '0);
                dec_amt    = DEC_MID;
            end
            RANGE_COARSE: begin
                field_zero = (state_q.cnt[CNT_W-1:COARSE_SHIFT] == '0);
                dec_amt    = DEC_COARSE;
            end
            default: begin
                field_zero = (state_q.cnt == '0);
                dec_amt    = DEC_FINE;
            end
        endcase

        tick    = enable && field_zero;
        state_d = state_q;
        if (!enable) begin
            state_d.cnt = '0;
        end else if (field_zero) begin
            state_d.cnt = period;
        end else begin
            state_d.cnt = state_q.cnt - dec_amt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/saw_stepper.sv
module saw_stepper #(
    parameter int RATE_W = 6,
    parameter int ACC_W  = 8,
    parameter int STEPS  = 14,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [STEP_W-1:0] step_o,
    output logic [ACC_W-1:0]  acc_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [ACC_W-1:0]  acc;
    } step_state_t;

    step_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = '0;
        end else if (tick) begin
            if (state_q.step == LAST_STEP) begin
                // wrap: clearing wins over the odd-step addition
                state_d.step = '0;
                state_d.acc  = '0;
            end else begin
                state_d.step = state_q.step + STEP_W'(1);
                if (state_q.step[0]) begin
                    state_d.acc = state_q.acc + ACC_W'(rate);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign step_o = state_q.step;
    assign acc_o  = state_q.acc;

endmodule

// File: rtl/saw_extract.sv
module saw_extract #(
    parameter int ACC_W = 8,
    parameter int OUT_W = 5
) (
    input  logic             enable,
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] sample
);
    always_comb begin
        if (enable && (acc != '0)) sample = acc[ACC_W-1 -: OUT_W];
        else                       sample = '0;
    end
endmodule

// File: rtl/saw_channel.sv
module saw_channel #(
    parameter int PERIOD_W     = 12,
    parameter int RATE_W       = 6,
    parameter int ACC_W        = 8,
    parameter int OUT_W        = 5,
    parameter int STEPS        = 14,
    parameter int MID_SHIFT    = 4,
    parameter int COARSE_SHIFT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    input  logic [RATE_W-1:0]   rate,
    input  logic [1:0]          range_sel,
    output logic [OUT_W-1:0]    sample
);
    localparam int STEP_W = $clog2(STEPS);

    logic              div_tick;
    logic [STEP_W-1:0] step_cnt;
    logic [ACC_W-1:0]  acc_val;

    saw_divider #(
        .CNT_W(PERIOD_W), .MID_SHIFT(MID_SHIFT), .COARSE_SHIFT(COARSE_SHIFT)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .period(period), .range_sel(range_sel), .tick(div_tick)
    );

    saw_stepper #(
        .RATE_W(RATE_W), .ACC_W(ACC_W), .STEPS(STEPS)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(div_tick),
        .rate(rate), .step_o(step_cnt), .acc_o(acc_val)
    );

    saw_extract #(
        .ACC_W(ACC_W), .OUT_W(OUT_W)
    ) u_ext (
        .enable(enable), .acc(acc_val), .sample(sample)
    );

endmodule

// File: rtl/saw_channel_chk.sv
module saw_channel_chk #(
    parameter int RATE_W = 6,
    parameter int ACC_W  = 8,
    parameter int OUT_W  = 5,
    parameter int STEPS  = 14,
    localparam int STEP_W = $clog2(STEPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              tick,
    input logic [RATE_W-1:0] rate,
    input logic [STEP_W-1:0] step,
    input logic [ACC_W-1:0]  acc,
    input logic [OUT_W-1:0]  sample
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST_STEP);

    p_wrap_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && step == LAST_STEP) |=> (step == '0 && acc == '0));

    p_odd_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && step[0] && step != LAST_STEP)
        |=> (acc == ACC_W'($past(acc) + ACC_W'($past(rate)))));

    p_even_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && !step[0]) |=> $stable(acc));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> ($stable(acc) && $stable(step)));

    p_disable_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (step == '0 && acc == '0));

    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == '0) |-> (sample == '0));

endmodule

bind saw_channel saw_channel_chk #(
    .RATE_W(RATE_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .STEPS(STEPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(div_tick),
    .rate(rate), .step(step_cnt), .acc(acc_val), .sample(sample)
);

// File: tb/saw_channel_bench.sv
`timescale 1ns/1ps
module saw_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] period = 12'd0;
    logic [5:0]  rate = 6'd0;
    logic [1:0]  range_sel = 2'd0;
    logic [4:0]  sample;

    int checks = 0;
    int errors = 0;

    // reference model state
    int         m_cnt = 0;
    int         m_step = 0;
    logic [7:0] m_acc = 8'd0;

    always #10 clk = ~clk;

    saw_channel u_saw_channel (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .rate(rate), .range_sel(range_sel), .sample(sample)
    );

    function automatic int reload_of(input logic [11:0] p, input logic [1:0] r);
        if (r[1])      return int'(p >> 8);
        else if (r[0]) return int'(p >> 4);
        else           return int'(p);
    endfunction

    function automatic logic [4:0] expect_of(input logic en, input logic [7:0] a);
        return en ? a[7:3] : 5'd0;
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sample=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model for the coming edge using the current inputs.
    task automatic model_edge();
        if (!enable) begin
            m_cnt = 0; m_step = 0; m_acc = 8'd0;
        end else if (m_cnt == 0) begin
            if (m_step == 13) begin
                m_step = 0; m_acc = 8'd0;
            end else begin
                if (m_step % 2 == 1) m_acc = m_acc + 8'(rate);
                m_step++;
            end
            m_cnt = reload_of(period, range_sel);
        end else begin
            m_cnt--;
        end
    endtask

    // Called just after a falling edge; runs n edges, optionally jittering rate.
    task automatic run(input string req, input int n, input bit jitter);
        for (int i = 0; i < n; i++) begin
            model_edge();
            @(posedge clk);
            #2;
            check(req, sample, expect_of(enable, m_acc));
            @(negedge clk);
            if (jitter) rate = 6'($urandom);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        #25;
        check("R1", sample, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        run("R1", 3, 1'b0);

        // R2: fine range, period 0 steps every edge; rate 8
        enable = 1'b1; period = 12'd0; rate = 6'd8; range_sel = 2'd0;
        run("R2", 30, 1'b0);
        // R2: period 3, rate 24
        enable = 1'b0; run("R7", 1, 1'b0);
        enable = 1'b1; period = 12'd3; rate = 6'd24;
        run("R2", 70, 1'b0);

        // R4/R5: large rate wraps modulo 256, step 13 clear wins
        enable = 1'b0; run("R7", 1, 1'b0);
        enable = 1'b1; period = 12'd1; rate = 6'd63;
        run("R4", 60, 1'b0);
        run("R5", 30, 1'b0);

        // R7: combinational silence, then clear at the next edge
        rate = 6'd40; period = 12'd0;
        run("R5", 6, 1'b0);
        check("R6", sample, expect_of(1'b1, m_acc));
        enable = 1'b0;
        #1;
        check("R7", sample, 5'd0);
        run("R7", 2, 1'b0);

        // R3: mid and coarse ranges, coarse ignores the low bit
        enable = 1'b1; period = 12'h025; range_sel = 2'd1; rate = 6'd32;
        run("R3", 80, 1'b0);
        enable = 1'b0; run("R7", 1, 1'b0);
        enable = 1'b1; period = 12'h3A7; range_sel = 2'd3;
        run("R3", 120, 1'b0);
        enable = 1'b0; run("R7", 1, 1'b0);
        enable = 1'b1; period = 12'h2FF; range_sel = 2'd2;
        run("R3", 100, 1'b0);

        // R8: random bursts, rate jitters every edge
        for (int b = 0; b < 40; b++) begin
            enable = 1'b0;
            range_sel = 2'($urandom);
            case (range_sel)
                2'd0:    period = 12'($urandom % 8);
                2'd1:    period = 12'($urandom % 128);
                default: period = 12'($urandom % 2048);
            endcase
            rate = 6'($urandom);
            run("R7", 1, 1'b0);
            enable = 1'b1;
            run("R8", 40 + int'($urandom % 40), 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule